// File: doc/BRIEF.md
# DMA Address Translation Table Unit

This block is the address translation stage of an I/O host bridge. Adapters issue DMA addresses. The block turns each one into a physical memory address through a small on-chip table of translation entries. The DMA page number selects one entry. The page offset passes through unchanged. The table is shared by every adapter, so each entry records the adapter slot that owns it. A lookup succeeds only for that slot, and only when the entry grants the needed access.

The table is loaded, changed and cleared through a separate write port. That port takes effect only while its privilege input is high, which is the path reserved for the hypervisor. Requests that fail the checks come back with an error flag and a zero address, so no memory access can be issued from them. Requests and responses each use a valid/ready handshake, and a result appears one cycle after its request is accepted.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, no response is pending (`rsp_valid` = 0, `req_ready` = 1), and every table entry is invalid, so any lookup returns an error.
- R2: A lookup whose entry is valid, is owned by `req_slot` and grants the access returns `rsp_err` = 0 and `rsp_addr` = {entry physical page, `req_addr[11:0]`}. The table index is `req_addr[17:12]`.
- R3: A lookup whose entry's slot differs from `req_slot` returns `rsp_err` = 1 and `rsp_addr` = 0.
- R4: A lookup whose entry is invalid returns `rsp_err` = 1 and `rsp_addr` = 0.
- R5: A read (`req_write` = 0) needs the entry's read-allow bit. A write (`req_write` = 1) needs its write-allow bit. A missing bit gives `rsp_err` = 1 and `rsp_addr` = 0.
- R6: A table write with `tw_priv` = 0 is ignored. Later lookups still see the old entry.
- R7: When a table write and a lookup hit the same index in the same cycle, the lookup returns the entry as it was before the write.
- R8: A request accepted on a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid` = 1 after that same edge.
- R9: While `rsp_valid` = 1 and `rsp_ready` = 0, the response holds its value and `req_ready` = 0. Once `rsp_ready` rises, a waiting request is accepted on that same edge.
- R10: A privileged write with `tw_vld` = 0 clears the entry. Later lookups to that index return an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_valid | input | 1 | Table write strobe |
| tw_priv | input | 1 | Privilege qualifier for the table write |
| tw_idx | input | 6 | Entry index to write |
| tw_vld | input | 1 | New entry valid bit |
| tw_rd | input | 1 | New entry read-allow bit |
| tw_wr | input | 1 | New entry write-allow bit |
| tw_slot | input | 4 | New entry owning slot |
| tw_ppn | input | 20 | New entry physical page number |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_slot | input | 4 | Requesting adapter slot |
| req_write | input | 1 | 1 = DMA write, 0 = DMA read |
| req_addr | input | 18 | DMA address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_err | output | 1 | Translation rejected |
| rsp_addr | output | 32 | Physical address, zero on error |

## Verification
The bench goes after an entry that is rewritten in the same cycle it is looked up. A design that forwards the new data would return the new page instead of the old one. It checks that an entry owned by another slot is rejected with a zero address. A design that drops the slot compare, or leaks the page on error, would issue an address on another partition's behalf. Unprivileged writes and read-only or write-only entries are exercised: a missing privilege gate would let the entry change, and a swapped permission bit would reject the legal direction. Response backpressure is held for several cycles. A design that lets the response drift or accepts a new request too early would show a changed address or lose one result.

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit #(
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 6,
  parameter int PPN_W     = 20,
  parameter int SLOT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tw_valid,
  input  logic                          tw_priv,
  input  logic [IDX_W-1:0]              tw_idx,
  input  logic                          tw_vld,
  input  logic                          tw_rd,
  input  logic                          tw_wr,
  input  logic [SLOT_W-1:0]             tw_slot,
  input  logic [PPN_W-1:0]              tw_ppn,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SLOT_W-1:0]             req_slot,
  input  logic                          req_write,
  input  logic [PAGE_BITS+IDX_W-1:0]    req_addr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_err,
  output logic [PPN_W+PAGE_BITS-1:0]    rsp_addr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  ent_vld, ent_rd, ent_wr;
  logic [SLOT_W-1:0] ent_slot [DEPTH];
  logic [PPN_W-1:0]  ent_ppn  [DEPTH];

  wire tw_go  = tw_valid && tw_priv;
  wire req_go = req_valid && req_ready;
  wire [IDX_W-1:0] idx = req_addr[PAGE_BITS +: IDX_W];
  wire perm_ok = req_write ? ent_wr[idx] : ent_rd[idx];
  wire hit = ent_vld[idx] && (ent_slot[idx] == req_slot) && perm_ok;

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_rd  <= '0;
      ent_wr  <= '0;
    end else if (tw_go) begin
      ent_vld[tw_idx] <= tw_vld;
      ent_rd[tw_idx]  <= tw_rd;
      ent_wr[tw_idx]  <= tw_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (tw_go) begin
      ent_slot[tw_idx] <= tw_slot;
      ent_ppn[tw_idx]  <= tw_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
    end else if (req_go) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !hit;
      rsp_addr  <= hit ? {ent_ppn[idx], req_addr[PAGE_BITS-1:0]} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_err_noaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_addr == '0);

  assert_unpriv_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid && !tw_priv |=> $stable(ent_vld) && $stable(ent_rd) && $stable(ent_wr));
endmodule

// File: tb/dma_xlate_unit_tb_top.sv
module dma_xlate_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic tw_valid = 0, tw_priv = 0, tw_vld = 0, tw_rd = 0, tw_wr = 0;
  logic [5:0] tw_idx = 0;
  logic [3:0] tw_slot = 0, req_slot = 0;
  logic [19:0] tw_ppn = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [17:0] req_addr = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_addr;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_xlate_unit dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic twrite(logic p, logic [5:0] i, logic v, logic r, logic w,
                        logic [3:0] s, logic [19:0] pp);
    @(negedge clk);
    tw_valid = 1; tw_priv = p; tw_idx = i; tw_vld = v; tw_rd = r; tw_wr = w;
    tw_slot = s; tw_ppn = pp;
    @(negedge clk);
    tw_valid = 0; tw_priv = 0;
  endtask

  task automatic lookup(string tag, logic [3:0] s, logic w, logic [17:0] a,
                        logic exp_err, logic [31:0] exp_addr);
    @(negedge clk);
    req_valid = 1; req_slot = s; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid (R8)"}, 32'(rsp_valid), 1);
    check({tag, " err"}, 32'(rsp_err), 32'(exp_err));
    check({tag, " addr"}, rsp_addr, exp_addr);
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    lookup("R1 empty", 4'd0, 1'b0, {6'd0, 12'h000}, 1, 0);
  endtask

  task automatic t_translate;
    twrite(1, 6'd5, 1, 1, 1, 4'd3, 20'hABCDE);
    lookup("R2 read", 4'd3, 0, {6'd5, 12'h123}, 0, {20'hABCDE, 12'h123});
    lookup("R2 write", 4'd3, 1, {6'd5, 12'hFFF}, 0, {20'hABCDE, 12'hFFF});
    twrite(1, 6'd63, 1, 1, 1, 4'd15, 20'hFFFFF);
    lookup("R2 top index", 4'd15, 0, {6'd63, 12'h001}, 0, {20'hFFFFF, 12'h001});
  endtask

  task automatic t_slot;
    lookup("R3 foreign slot", 4'd4, 0, {6'd5, 12'h123}, 1, 0);
  endtask

  task automatic t_invalid;
    lookup("R4 never written", 4'd3, 0, {6'd9, 12'h010}, 1, 0);
  endtask

  task automatic t_perm;
    twrite(1, 6'd6, 1, 1, 0, 4'd2, 20'h11111);
    twrite(1, 6'd7, 1, 0, 1, 4'd2, 20'h22222);
    lookup("R5 ro read", 4'd2, 0, {6'd6, 12'h040}, 0, {20'h11111, 12'h040});
    lookup("R5 ro write", 4'd2, 1, {6'd6, 12'h040}, 1, 0);
    lookup("R5 wo read", 4'd2, 0, {6'd7, 12'h080}, 1, 0);
    lookup("R5 wo write", 4'd2, 1, {6'd7, 12'h080}, 0, {20'h22222, 12'h080});
  endtask

  task automatic t_unpriv;
    twrite(0, 6'd5, 1, 1, 1, 4'd9, 20'h55555);
    lookup("R6 old kept", 4'd3, 0, {6'd5, 12'h200}, 0, {20'hABCDE, 12'h200});
    twrite(0, 6'd10, 1, 1, 1, 4'd1, 20'h12345);
    lookup("R6 no create", 4'd1, 0, {6'd10, 12'h000}, 1, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    tw_valid = 1; tw_priv = 1; tw_idx = 6'd5; tw_vld = 1; tw_rd = 1; tw_wr = 1;
    tw_slot = 4'd3; tw_ppn = 20'h33333;
    req_valid = 1; req_slot = 4'd3; req_write = 0; req_addr = {6'd5, 12'h0AA};
    @(negedge clk);
    tw_valid = 0; tw_priv = 0; req_valid = 0;
    check("R7 old err", 32'(rsp_err), 0);
    check("R7 old addr", rsp_addr, {20'hABCDE, 12'h0AA});
    lookup("R7 new", 4'd3, 0, {6'd5, 12'h0AA}, 0, {20'h33333, 12'h0AA});
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_slot = 4'd3; req_write = 0; req_addr = {6'd5, 12'h111};
    @(negedge clk);
    check("R8 valid", 32'(rsp_valid), 1);
    check("R9 ready low", 32'(req_ready), 0);
    req_addr = {6'd6, 12'h222}; req_slot = 4'd2;
    repeat (3) @(negedge clk);
    check("R9 held valid", 32'(rsp_valid), 1);
    check("R9 held addr", rsp_addr, {20'h33333, 12'h111});
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R9 second valid", 32'(rsp_valid), 1);
    check("R9 second addr", rsp_addr, {20'h11111, 12'h222});
    @(negedge clk);
    check("R9 drained", 32'(rsp_valid), 0);
  endtask

  task automatic t_clear;
    twrite(1, 6'd6, 0, 1, 1, 4'd2, 20'h11111);
    lookup("R10 cleared", 4'd2, 0, {6'd6, 12'h040}, 1, 0);
    lookup("R10 other kept", 4'd2, 1, {6'd7, 12'h000}, 0, {20'h22222, 12'h000});
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_slot();
    t_invalid();
    t_perm();
    t_unpriv();
    t_same_cycle();
    t_backpressure();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule